// File: doc/BRIEF.md
# Coprocessor Integer Execute Unit

This block carries out the integer data-processing operations of a coprocessor that owns sixteen 64-bit registers. A register serves either as a 32-bit integer held in its lower half or as a 64-bit integer spanning both halves. Each issued instruction word is decoded, two source registers (and, for multiply-accumulate forms, the destination's old value) are read, and the result is written back in the same clock edge. The write covers only the lower half for 32-bit operations and all 64 bits for 64-bit ones.

Supported work is addition, subtraction, negation, absolute value, multiplication, multiply-add and multiply-subtract into the destination, and shifts. A shift takes its amount either from a 7-bit signed immediate packed into the instruction or from a signed 32-bit amount supplied by the host. The sign of that amount picks the direction, and right shifts keep the sign. A host load port fills registers, and a peek port reads any register back.

Top module: `iex_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every register, `done_o` and `undef_o` become zero.
- R2: An instruction issued with `issue_i` high at an edge takes its destination index from bits 15:12, source A from bits 19:16 and source B from bits 3:0. The result is visible on the peek port and `done_o` is high for exactly the one cycle after that edge. No other register changes.
- R3: Bits 21:20 = 3 selects the arithmetic group, where bits 7:5 give 4 add32, 5 add64, 6 sub32, 7 sub64. All results wrap modulo 2^width.
- R4: In the arithmetic group, codes 0 abs32, 1 abs64, 2 neg32 and 3 neg64 work in two's complement. The absolute value of the most negative number is that number itself.
- R5: Every 32-bit operation writes bits 31:0 of the destination and leaves bits 63:32 unchanged.
- R6: Bits 21:20 = 1 selects the multiply group. Code 0 gives the low 32 bits of the product of the two lower halves, and code 1 gives the low 64 bits of the product of the two full registers.
- R7: In the multiply group, code 2 adds the 32-bit product of the sources to the destination's lower half. Code 3 subtracts that product from it. Both wrap.
- R8: Bits 21:20 = 0 (32-bit) and 2 (64-bit) shift source A by the signed 7-bit immediate {bits 7:5, bits 3:0}, whose bit 6 is the sign. Zero or positive shifts left, and negative shifts arithmetically right by the magnitude.
- R9: A shift magnitude equal to or above the operand width (32 or 64) gives zero for a left shift and copies of the sign bit for a right shift.
- R10: With `rs_mode_i` high, code 2 in bits 7:5 gives a 32-bit shift and code 3 a 64-bit shift. The source is bits 19:16, the destination is bits 3:0, and bits 15:12 and 21:20 are ignored. A host amount above zero shifts left by that amount; otherwise the operand shifts arithmetically right by the negated amount.
- R11: An undefined code reads as `undef_o` and `done_o` high in the cycle after issue and leaves every register unchanged. The undefined codes are codes 4 to 7 of the multiply group and any code other than 2 or 3 in host-amount mode.
- R12: `ld_en_i` writes `ld_data_i` into register `ld_idx_i` at the edge, but only when no instruction issues in that cycle; an issue blocks the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Execute `instr_i` at this edge |
| rs_mode_i | input | 1 | Take the shift amount from `host_amt_i` |
| instr_i | input | 32 | Instruction word |
| host_amt_i | input | 32 | Signed shift amount from the host |
| ld_en_i | input | 1 | Host register load enable |
| ld_idx_i | input | 4 | Host load register index |
| ld_data_i | input | 64 | Host load value |
| pk_idx_i | input | 4 | Peek register index |
| pk_data_o | output | 64 | Peeked register contents |
| done_o | output | 1 | An instruction completed at the last edge |
| undef_o | output | 1 | The completed instruction was undefined |

## Verification
The bench goes after signed shift edges. These are the immediate of -64, whose magnitude does not fit six bits, a host amount of the most negative 32-bit value, and magnitudes of exactly 32 or 64. A design that dropped the clamp would wrap the amount and return a shifted value instead of zero or sign fill. A design with a logical right shift would lose the sign. It also checks that 32-bit writes keep the upper half, which a full-width write would wipe. It checks that abs of the most negative value and multiply-subtract below zero wrap rather than saturate. It checks that undefined codes and a load colliding with an issue leave the register file untouched, where a careless design would write garbage or honour the load.

// File: rtl/iex_pkg.sv
package iex_pkg;
    localparam int XLEN = 64;
    localparam int HALF = XLEN / 2;
    localparam int FLDW = 4;
    localparam int SHW  = $clog2(XLEN);
    localparam int SHWH = $clog2(HALF);

    typedef enum logic [3:0] {
        K_NOP, K_ADD, K_SUB, K_NEG, K_ABS, K_MUL, K_MAC, K_MSC, K_SHF
    } kind_e;

    typedef enum logic [1:0] {WB_NONE, WB_LOW, WB_FULL} wb_e;

    typedef struct packed {
        logic [FLDW-1:0] dst;
        logic [FLDW-1:0] sa;
        logic [FLDW-1:0] sb;
        kind_e           kind;
        logic            wide;
        wb_e             wb;
        logic            undef;
        logic            sh_left;
        logic [HALF:0]   sh_mag;
    } uop_t;

    // Signed-direction shift with clamping of large magnitudes.
    function automatic logic [XLEN-1:0] shift_val(
        input logic [XLEN-1:0] v,
        input logic            wide,
        input logic            left,
        input logic [HALF:0]   mag
    );
        logic [HALF-1:0] lo;
        logic [HALF-1:0] rl;
        logic [XLEN-1:0] r;
        lo = v[HALF-1:0];
        r  = '0;
        rl = '0;
        if (wide) begin
            if (mag >= (HALF+1)'(XLEN))
                r = left ? '0 : {XLEN{v[XLEN-1]}};
            else if (left)
                r = v << mag[SHW-1:0];
            else
                r = $signed(v) >>> mag[SHW-1:0];
        end else begin
            if (mag >= (HALF+1)'(HALF))
                rl = left ? '0 : {HALF{lo[HALF-1]}};
            else if (left)
                rl = lo << mag[SHWH-1:0];
            else
                rl = $signed(lo) >>> mag[SHWH-1:0];
            r = {{HALF{1'b0}}, rl};
        end
        return r;
    endfunction
endpackage

// File: rtl/iex_decode.sv
module iex_decode
    import iex_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        rs_mode,
    input  logic [31:0] host_amt,
    output uop_t        uop
);
    logic [1:0] grp;
    logic [2:0] code;
    logic [6:0] imm7;
    logic [6:0] imm_mag;
    logic       unused_bits;

    assign grp     = instr[21:20];
    assign code    = instr[7:5];
    assign imm7    = {instr[7:5], instr[3:0]};
    assign imm_mag = imm7[6] ? (~imm7 + 7'd1) : imm7;
    assign unused_bits = ^{instr[31:22], instr[11:8], instr[4]};

    always_comb begin
        uop         = '0;
        uop.dst     = instr[15:12];
        uop.sa      = instr[19:16];
        uop.sb      = instr[3:0];
        uop.kind    = K_NOP;
        uop.wb      = WB_NONE;
        uop.sh_left = ~imm7[6];
        uop.sh_mag  = (HALF+1)'(imm_mag);
        if (rs_mode) begin
            uop.dst     = instr[3:0];
            uop.sh_left = $signed(host_amt) > 0;
            uop.sh_mag  = uop.sh_left ? {1'b0, host_amt}
                                      : ((HALF+1)'(0) - {host_amt[31], host_amt});
            case (code)
                3'd2: begin uop.kind = K_SHF; uop.wb = WB_LOW; end
                3'd3: begin uop.kind = K_SHF; uop.wide = 1'b1; uop.wb = WB_FULL; end
                default: uop.undef = 1'b1;
            endcase
        end else begin
            case (grp)
                2'd0: begin uop.kind = K_SHF; uop.wb = WB_LOW; end
                2'd2: begin uop.kind = K_SHF; uop.wide = 1'b1; uop.wb = WB_FULL; end
                2'd1: begin
                    case (code)
                        3'd0: begin uop.kind = K_MUL; uop.wb = WB_LOW; end
                        3'd1: begin uop.kind = K_MUL; uop.wide = 1'b1; uop.wb = WB_FULL; end
                        3'd2: begin uop.kind = K_MAC; uop.wb = WB_LOW; end
                        3'd3: begin uop.kind = K_MSC; uop.wb = WB_LOW; end
                        default: uop.undef = 1'b1;
                    endcase
                end
                default: begin
                    uop.wide = code[0];
                    uop.wb   = code[0] ? WB_FULL : WB_LOW;
                    case (code[2:1])
                        2'd0: uop.kind = K_ABS;
                        2'd1: uop.kind = K_NEG;
                        2'd2: uop.kind = K_ADD;
                        default: uop.kind = K_SUB;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/iex_alu.sv
module iex_alu
    import iex_pkg::*;
(
    input  kind_e           kind,
    input  logic            wide,
    input  logic            sh_left,
    input  logic [HALF:0]   sh_mag,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [XLEN-1:0] opd,
    output logic [XLEN-1:0] res
);
    logic [HALF-1:0] la, lb, ld, prod32;
    logic [XLEN-1:0] prod64;
    logic            unused_hi;

    assign la        = opa[HALF-1:0];
    assign lb        = opb[HALF-1:0];
    assign ld        = opd[HALF-1:0];
    assign unused_hi = ^opd[XLEN-1:HALF];
    assign prod32    = la * lb;
    assign prod64    = opa * opb;

    always_comb begin
        res = '0;
        case (kind)
            K_ADD: res = wide ? opa + opb : {{HALF{1'b0}}, la + lb};
            K_SUB: res = wide ? opa - opb : {{HALF{1'b0}}, la - lb};
            K_NEG: res = wide ? -opa : {{HALF{1'b0}}, -la};
            K_ABS: res = wide ? (opa[XLEN-1] ? -opa : opa)
                              : {{HALF{1'b0}}, (la[HALF-1] ? -la : la)};
            K_MUL: res = wide ? prod64 : {{HALF{1'b0}}, prod32};
            K_MAC: res = {{HALF{1'b0}}, ld + prod32};
            K_MSC: res = {{HALF{1'b0}}, ld - prod32};
            K_SHF: res = shift_val(opa, wide, sh_left, sh_mag);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/iex_regfile.sv
module iex_regfile
    import iex_pkg::*;
#(
    parameter int IDXW = FLDW,
    parameter int W    = XLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            wfull,
    input  logic [IDXW-1:0] widx,
    input  logic [W-1:0]    wdata,
    input  logic            ld_en,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [W-1:0]    ld_data,
    input  logic [IDXW-1:0] ra,
    input  logic [IDXW-1:0] rb,
    input  logic [IDXW-1:0] rd,
    input  logic [IDXW-1:0] rp,
    output logic [W-1:0]    qa,
    output logic [W-1:0]    qb,
    output logic [W-1:0]    qd,
    output logic [W-1:0]    qp
);
    localparam int DEPTH = 1 << IDXW;
    localparam int LOW   = W / 2;

    logic [DEPTH-1:0][W-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (we) begin
            if (wfull) mem[widx] <= wdata;
            else       mem[widx][LOW-1:0] <= wdata[LOW-1:0];
        end else if (ld_en) begin
            mem[ld_idx] <= ld_data;
        end
    end

    assign qa = mem[ra];
    assign qb = mem[rb];
    assign qd = mem[rd];
    assign qp = mem[rp];

    // R5: a half-width write never disturbs the upper half
    p_low_write_keeps_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (we && !wfull) |=> mem[$past(widx)][W-1:LOW] == $past(mem[widx][W-1:LOW]));

    // R11: with no write and no load the whole file holds
    p_quiet_holds_state_r11: assert property (@(posedge clk) disable iff (rst)
        (!we && !ld_en) |=> $stable(mem));
endmodule

// File: rtl/iex_unit.sv
module iex_unit
    import iex_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_i,
    input  logic             rs_mode_i,
    input  logic [31:0]      instr_i,
    input  logic [31:0]      host_amt_i,
    input  logic             ld_en_i,
    input  logic [FLDW-1:0]  ld_idx_i,
    input  logic [XLEN-1:0]  ld_data_i,
    input  logic [FLDW-1:0]  pk_idx_i,
    output logic [XLEN-1:0]  pk_data_o,
    output logic             done_o,
    output logic             undef_o
);
    uop_t            uop;
    logic [XLEN-1:0] opa, opb, opd, alu_res;
    logic            rf_we, rf_full, rf_ld;
    logic            done_q, undef_q;

    iex_decode u_dec (
        .instr    (instr_i),
        .rs_mode  (rs_mode_i),
        .host_amt (host_amt_i),
        .uop      (uop)
    );

    iex_alu u_alu (
        .kind    (uop.kind),
        .wide    (uop.wide),
        .sh_left (uop.sh_left),
        .sh_mag  (uop.sh_mag),
        .opa     (opa),
        .opb     (opb),
        .opd     (opd),
        .res     (alu_res)
    );

    assign rf_we   = issue_i && !uop.undef && (uop.wb != WB_NONE);
    assign rf_full = (uop.wb == WB_FULL);
    assign rf_ld   = ld_en_i && !issue_i;

    iex_regfile #(.IDXW(FLDW), .W(XLEN)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .wfull   (rf_full),
        .widx    (uop.dst),
        .wdata   (alu_res),
        .ld_en   (rf_ld),
        .ld_idx  (ld_idx_i),
        .ld_data (ld_data_i),
        .ra      (uop.sa),
        .rb      (uop.sb),
        .rd      (uop.dst),
        .rp      (pk_idx_i),
        .qa      (opa),
        .qb      (opb),
        .qd      (opd),
        .qp      (pk_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            undef_q <= 1'b0;
        end else begin
            done_q  <= issue_i;
            undef_q <= issue_i && uop.undef;
        end
    end

    assign done_o  = done_q;
    assign undef_o = undef_q;

    // R11: an undefined flag only accompanies a completion
    p_undef_with_done_r11: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> done_o);

    // R8: a zero shift magnitude returns the source unchanged
    p_shift_zero_identity_r8: assert property (@(posedge clk) disable iff (rst)
        (issue_i && uop.kind == K_SHF && uop.sh_mag == '0) |->
        (uop.wide ? (alu_res == opa) : (alu_res[HALF-1:0] == opa[HALF-1:0])));

    // R4: 64-bit abs is non-negative except for the most negative value
    p_abs_nonneg_r4: assert property (@(posedge clk) disable iff (rst)
        (issue_i && uop.kind == K_ABS && uop.wide && opa != {1'b1, {(XLEN-1){1'b0}}}) |->
        !alu_res[XLEN-1]);

    // R2: a completion is reported only after an issue
    p_done_after_issue_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(issue_i));
endmodule

// File: tb/tb_iex_unit.sv
module tb_iex_unit;
    localparam int CLK_NS = 10;
    localparam int NV     = 26;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  grp;
        logic [2:0]  code;
        logic [3:0]  lo4;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] d;
        logic [63:0] exp;
    } vec_t;

    // Source A in r1, source B in r2, destination r3.
    localparam vec_t VT [NV] = '{
        '{4'd3, 2'd3, 3'd4, 4'd2, 64'hAAAAAAAA_00000005, 64'h11111111_FFFFFFFF, 64'hDEADBEEF_12345678, 64'hDEADBEEF_00000004}, // R3 R5
        '{4'd3, 2'd3, 3'd5, 4'd2, 64'h00000001_FFFFFFFF, 64'h1, 64'h0, 64'h00000002_00000000},                              // R3
        '{4'd3, 2'd3, 3'd6, 4'd2, 64'h3, 64'h5, 64'h12345678_00000000, 64'h12345678_FFFFFFFE},                              // R3
        '{4'd3, 2'd3, 3'd7, 4'd2, 64'h0, 64'h1, 64'h0, 64'hFFFFFFFF_FFFFFFFF},                                              // R3
        '{4'd4, 2'd3, 3'd0, 4'd2, 64'h55555555_FFFFFFF6, 64'h0, 64'hCAFEF00D_00000000, 64'hCAFEF00D_0000000A},              // R4
        '{4'd4, 2'd3, 3'd0, 4'd2, 64'h80000000, 64'h0, 64'h0, 64'h80000000},                                                // R4
        '{4'd4, 2'd3, 3'd1, 4'd2, 64'hFFFFFFFF_FFFFFFFE, 64'h0, 64'h0, 64'h2},                                              // R4
        '{4'd4, 2'd3, 3'd2, 4'd2, 64'h1, 64'h0, 64'hAAAAAAAA_00000000, 64'hAAAAAAAA_FFFFFFFF},                              // R4
        '{4'd4, 2'd3, 3'd3, 4'd2, 64'h5, 64'h0, 64'h0, 64'hFFFFFFFF_FFFFFFFB},                                              // R4
        '{4'd4, 2'd3, 3'd1, 4'd2, 64'h80000000_00000000, 64'h0, 64'h0, 64'h80000000_00000000},                              // R4
        '{4'd6, 2'd1, 3'd0, 4'd2, 64'h00010000, 64'h00010003, 64'h77777777_00000000, 64'h77777777_00030000},                // R6
        '{4'd6, 2'd1, 3'd0, 4'd2, 64'hFFFFFFFD, 64'h7, 64'h0, 64'hFFFFFFEB},                                                // R6
        '{4'd6, 2'd1, 3'd1, 4'd2, 64'h00000001_00000001, 64'h00000001_00000001, 64'h0, 64'h00000002_00000001},              // R6
        '{4'd7, 2'd1, 3'd2, 4'd2, 64'h6, 64'h7, 64'h99999999_00000064, 64'h99999999_0000008E},                              // R7
        '{4'd7, 2'd1, 3'd3, 4'd2, 64'h3, 64'h4, 64'h0000000A, 64'hFFFFFFFE},                                                // R7
        '{4'd8, 2'd0, 3'd0, 4'd4, 64'hFFFF0000_000000F1, 64'h0, 64'hBBBBBBBB_00000000, 64'hBBBBBBBB_00000F10},              // R8 +4
        '{4'd8, 2'd0, 3'd7, 4'hC, 64'h80000010, 64'h0, 64'h0, 64'hF8000001},                                                // R8 -4
        '{4'd9, 2'd0, 3'd2, 4'd8, 64'hFFFFFFFF, 64'h0, 64'h11111111_22222222, 64'h11111111_00000000},                       // R9 +40
        '{4'd9, 2'd0, 3'd4, 4'd0, 64'h80000000, 64'h0, 64'h0, 64'hFFFFFFFF},                                                // R9 -64
        '{4'd9, 2'd0, 3'd5, 4'hF, 64'h7FFFFFFF, 64'h0, 64'h0, 64'h0},                                                       // R9 -33
        '{4'd8, 2'd2, 3'd3, 4'hF, 64'h1, 64'h0, 64'h0, 64'h80000000_00000000},                                              // R8 +63
        '{4'd8, 2'd2, 3'd7, 4'hF, 64'h80000000_00000002, 64'h0, 64'h0, 64'hC0000000_00000001},                              // R8 -1
        '{4'd8, 2'd2, 3'd0, 4'd0, 64'h12345678_9ABCDEF0, 64'h0, 64'h0, 64'h12345678_9ABCDEF0},                              // R8 0
        '{4'd9, 2'd2, 3'd4, 4'd0, 64'h80000000_00000000, 64'h0, 64'h0, 64'hFFFFFFFF_FFFFFFFF},                              // R9 -64
        '{4'd8, 2'd2, 3'd2, 4'd4, 64'hAB, 64'h0, 64'h0, 64'h00000AB0_00000000},                                             // R8 +36
        '{4'd9, 2'd2, 3'd4, 4'd0, 64'h40000000_00000000, 64'h0, 64'h0, 64'h0}                                               // R9 -64
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_i = 1'b0;
    logic        rs_mode_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] host_amt_i = '0;
    logic        ld_en_i = 1'b0;
    logic [3:0]  ld_idx_i = '0;
    logic [63:0] ld_data_i = '0;
    logic [3:0]  pk_idx_i = '0;
    logic [63:0] pk_data_o;
    logic        done_o, undef_o;

    int n_chk = 0;
    int n_err = 0;
    bit ended = 1'b0;

    iex_unit dut (
        .clk(clk), .rst(rst), .issue_i(issue_i), .rs_mode_i(rs_mode_i),
        .instr_i(instr_i), .host_amt_i(host_amt_i), .ld_en_i(ld_en_i),
        .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i), .pk_idx_i(pk_idx_i),
        .pk_data_o(pk_data_o), .done_o(done_o), .undef_o(undef_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [31:0] mk(input logic [1:0] grp, input logic [2:0] code,
                                       input logic [3:0] s1, input logic [3:0] dst,
                                       input logic [3:0] lo4);
        return {10'd0, grp, s1, dst, 4'd0, code, 1'b0, lo4};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] idx, input logic [63:0] val);
        @(negedge clk);
        ld_en_i = 1'b1; ld_idx_i = idx; ld_data_i = val;
        @(negedge clk);
        ld_en_i = 1'b0;
    endtask

    task automatic issue(input logic [31:0] ins, input logic rs, input logic [31:0] amt);
        @(negedge clk);
        instr_i = ins; rs_mode_i = rs; host_amt_i = amt; issue_i = 1'b1;
        @(negedge clk);
        issue_i = 1'b0; rs_mode_i = 1'b0;
    endtask

    function automatic logic [63:0] peek_now(input logic [3:0] idx);
        return 64'(idx);
    endfunction

    task automatic peek(input logic [3:0] idx, output logic [63:0] v);
        pk_idx_i = idx;
        #1;
        v = pk_data_o;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        logic [63:0] unused_probe;
        unused_probe = peek_now(4'd0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", {63'd0, done_o}, 64'd0);
        chk("R1 undef", {63'd0, undef_o}, 64'd0);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            peek(4'(i), v);
            chk("R1 reg", v, 64'd0);
        end

        // Vector table: R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            load(4'd1, VT[k].a);
            load(4'd2, VT[k].b);
            load(4'd3, VT[k].d);
            issue(mk(VT[k].grp, VT[k].code, 4'd1, 4'd3, VT[k].lo4), 1'b0, 32'd0);
            chk("R2 done", {62'd0, done_o, undef_o}, 64'd2);
            peek(4'd3, v);
            n_chk++;
            if (v !== VT[k].exp) begin
                n_err++;
                $display("FAIL R%0d row %0d: actual=%h expected=%h", VT[k].req, k, v, VT[k].exp);
            end
        end

        // R2: done lasts one cycle; sources untouched
        @(negedge clk);
        chk("R2 done drops", {63'd0, done_o}, 64'd0);
        peek(4'd1, v);
        chk("R2 src A kept", v, 64'h40000000_00000000);

        // R11: undefined multiply-group codes
        for (int c = 4; c < 8; c++) begin
            load(4'd3, 64'h0BAD0BAD_5EED5EED);
            issue(mk(2'd1, 3'(c), 4'd1, 4'd3, 4'd2), 1'b0, 32'd0);
            chk("R11 flags", {62'd0, done_o, undef_o}, 64'd3);
            peek(4'd3, v);
            chk("R11 reg kept", v, 64'h0BAD0BAD_5EED5EED);
        end

        // R10: host-amount shifts, dest from bits 3:0 (r5), bits 15:12 name r14
        load(4'd1, 64'h00000000_00000001);
        load(4'd5, 64'hFEEDFACE_00000000);
        issue(mk(2'd3, 3'd2, 4'd1, 4'hE, 4'd5), 1'b1, 32'd3);
        peek(4'd5, v);  chk("R10 left 3", v, 64'hFEEDFACE_00000008);
        peek(4'hE, v);  chk("R10 r14 untouched", v, 64'd0);
        issue(mk(2'd0, 3'd2, 4'd1, 4'hE, 4'd5), 1'b1, 32'd0);
        peek(4'd5, v);  chk("R10 zero amount", v, 64'hFEEDFACE_00000001);
        load(4'd1, 64'h00000000_80000000);
        issue(mk(2'd0, 3'd2, 4'd1, 4'hE, 4'd5), 1'b1, 32'hFFFFFFFE);
        peek(4'd5, v);  chk("R10 right 2", v, 64'hFEEDFACE_E0000000);
        load(4'd1, 64'h80000000_00000000);
        issue(mk(2'd0, 3'd3, 4'd1, 4'hE, 4'd5), 1'b1, 32'hFFFFFFBA);
        peek(4'd5, v);  chk("R10 R9 right 70", v, 64'hFFFFFFFF_FFFFFFFF);
        load(4'd5, 64'd0);
        issue(mk(2'd0, 3'd3, 4'd1, 4'hE, 4'd5), 1'b1, 32'h80000000);
        peek(4'd5, v);  chk("R10 R9 most negative", v, 64'hFFFFFFFF_FFFFFFFF);
        load(4'd1, 64'd1);
        issue(mk(2'd0, 3'd3, 4'd1, 4'hE, 4'd5), 1'b1, 32'd63);
        peek(4'd5, v);  chk("R10 left 63", v, 64'h80000000_00000000);
        issue(mk(2'd0, 3'd3, 4'd1, 4'hE, 4'd5), 1'b1, 32'd64);
        peek(4'd5, v);  chk("R10 R9 left 64", v, 64'd0);

        // R11: host-amount mode with an undefined code
        load(4'd5, 64'h13579BDF_2468ACE0);
        issue(mk(2'd0, 3'd0, 4'd1, 4'hE, 4'd5), 1'b1, 32'd1);
        chk("R11 rs flags", {62'd0, done_o, undef_o}, 64'd3);
        peek(4'd5, v);  chk("R11 rs reg kept", v, 64'h13579BDF_2468ACE0);

        // R12: a load in the same cycle as an issue is dropped
        load(4'd1, 64'd7);
        load(4'd2, 64'd8);
        @(negedge clk);
        instr_i = mk(2'd3, 3'd5, 4'd1, 4'd3, 4'd2); issue_i = 1'b1;
        ld_en_i = 1'b1; ld_idx_i = 4'd7; ld_data_i = 64'h1234;
        @(negedge clk);
        issue_i = 1'b0; ld_en_i = 1'b0;
        peek(4'd7, v);  chk("R12 load dropped", v, 64'd0);
        peek(4'd3, v);  chk("R12 issue wins", v, 64'd15);
        load(4'd7, 64'h1234);
        peek(4'd7, v);  chk("R12 load alone", v, 64'h1234);

        finish_run();
    end
endmodule